// File: doc/BRIEF.md
# Interrupt Line Mapper with Enable Gating

This unit passes level-sensitive interrupt lines to interrupt-vector outputs, one output per input, and blocks or admits each line according to an enable flag held in a map register. There are 48 lines in two families. The 32 bus-slot lines share their map registers in groups of four: line j is controlled by slot map register j >> 2. Each of the 16 on-board lines has a map register of its own: line 32 + k is controlled by on-board map register k. An admitted line copies its input level straight to its output. A blocked line drives its output low.

Software reaches the map registers through a plain 32-bit port: an address, a write strobe, write data, and read data that follows the address without a clock. Each map register takes the upper word of an 8-byte slot. The slot family starts at offset 0xC00 and the on-board family starts at offset 0x1000. Bit 31 is the only bit that can be written. The slot registers read back fixed low bits that come from their index.

There are two resets. An asynchronous power-on reset (`por_n`) places every register in its initial state. A synchronous device reset (`dev_rst`) blocks the slot family and leaves the on-board family as it was. The unit has no state machine. Its state is the 24 enable flops.

Top module: `irq_route_unit`

## Requirements
- R1: While `por_n` is low and after it is released, all enables are 0 and every output is low for any input. Slot register i (at 0xC04 + 8*i) reads (0x1F << 6) | (i << 2). Every on-board register (at 0x1004 + 8*k) reads 0.
- R2: A write to a map register's upper word sets its enable to write-data bit 31. Write-data bits 30:0 are ignored. A read returns {enable, fixed low bits}.
- R3: Output j (0..31) equals input j when slot enable j >> 2 is 1, and is 0 otherwise.
- R4: Output 32 + k (k = 0..15) equals input 32 + k when on-board enable k is 1, and is 0 otherwise.
- R5: Outputs are combinational in the inputs and enables. A write that clears an enable drops the gated outputs right after the clock edge that takes the write.
- R6: An address with bit 2 = 0 reads as 0, and a write to it changes nothing.
- R7: An upper-word address outside 0xC00–0xC3F and 0x1000–0x107F reads as 0, and a write to it changes nothing. Address bits 1:0 do not take part in the decode.
- R8: A cycle with `dev_rst` high clears all 8 slot enables. It keeps the slot low bits and all on-board enables.
- R9: When `dev_rst` and a slot write fall in the same cycle, the clear wins. An on-board write in a reset cycle still takes effect.
- R10: A write takes effect at the clock edge that ends its cycle. Reads follow `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst | input | 1 | Synchronous device reset; clears the slot enables |
| reg_addr | input | 16 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; only bit 31 is used |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_in | input | 48 | Interrupt input levels; 0..31 slot lines, 32..47 on-board lines |
| ivec_out | output | 48 | Gated interrupt-vector outputs |

## Verification
Two pairs of actions can fall in the same clock cycle. The first pair is a device reset and a register write. The bench raises `dev_rst` in the cycle of a slot write and expects the enable to read 0 afterwards. It repeats this with an on-board write and expects the new enable to read back. The second pair is a live input and a write that clears its enable. The bench holds the line high, checks that the output is high before the edge, and checks that it is low just after the edge that takes the write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_SLOT  = 2'd1,
        RG_BOARD = 2'd2
    } irq_region_e;

    localparam int unsigned MAP_STRIDE = 8;

    // Fixed low bits of slot map register i.
    function automatic logic [30:0] slot_low_bits(input int unsigned i);
        logic [31:0] v;
        v = 32'h0000_07C0 | (i << 2);
        return v[30:0];
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SLOT_BASE = 'hC00,
    parameter int N_SLOT    = 8,
    parameter int BRD_BASE  = 'h1000,
    parameter int N_BRD     = 16,
    parameter int SIW       = 3,
    parameter int BIW       = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output irq_region_e       region,
    output logic [SIW-1:0]    slot_idx,
    output logic [BIW-1:0]    brd_idx
);
    localparam logic [ADDR_W:0] SLOT_LO = (ADDR_W+1)'(SLOT_BASE);
    localparam logic [ADDR_W:0] SLOT_HI = (ADDR_W+1)'(SLOT_BASE + N_SLOT * MAP_STRIDE);
    localparam logic [ADDR_W:0] BRD_LO  = (ADDR_W+1)'(BRD_BASE);
    localparam logic [ADDR_W:0] BRD_HI  = (ADDR_W+1)'(BRD_BASE + N_BRD * MAP_STRIDE);

    logic [ADDR_W:0]   addr_x;
    logic [ADDR_W-1:0] slot_off;
    logic [ADDR_W-1:0] brd_off;
    logic              unused_off_bits;

    assign addr_x   = {1'b0, addr};
    assign slot_off = addr - SLOT_LO[ADDR_W-1:0];
    assign brd_off  = addr - BRD_LO[ADDR_W-1:0];
    assign slot_idx = slot_off[3 +: SIW];
    assign brd_idx  = brd_off[3 +: BIW];
    assign unused_off_bits = ^{slot_off, brd_off};

    always_comb begin
        region = RG_NONE;
        if (addr[2]) begin
            if (addr_x >= SLOT_LO && addr_x < SLOT_HI) begin
                region = RG_SLOT;
            end else if (addr_x >= BRD_LO && addr_x < BRD_HI) begin
                region = RG_BOARD;
            end
        end
    end

endmodule

// File: rtl/irq_route_enbank.sv
module irq_route_enbank #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic          wen,
    output logic [N-1:0]  en
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en <= '0;
        end else if (clr) begin
            en <= '0;
        end else if (wr) begin
            en[idx] <= wen;
        end
    end

    // R8 / R9: a clear cycle leaves every enable of the bank at zero
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (en == '0));

    // R2: an accepted write lands its bit in the addressed enable
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!por_n)
        (wr && !clr) |=> (en[$past(idx)] == $past(wen)));

    // R6 / R7: without write or clear the bank holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!por_n)
        (!wr && !clr) |=> $stable(en));

endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate #(
    parameter int N_GRP   = 8,
    parameter int PER_GRP = 4,
    parameter int N_BRD   = 16
) (
    input  logic                           clk,
    input  logic                           por_n,
    input  logic [N_GRP*PER_GRP+N_BRD-1:0] irq_in,
    input  logic [N_GRP-1:0]               slot_en,
    input  logic [N_BRD-1:0]               brd_en,
    output logic [N_GRP*PER_GRP+N_BRD-1:0] ivec_out
);
    localparam int N_SLOT_LINES = N_GRP * PER_GRP;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar l = 0; l < PER_GRP; l++) begin : g_line
            assign ivec_out[g*PER_GRP + l] = irq_in[g*PER_GRP + l] & slot_en[g];
        end
        // R3: a blocked group shows no activity
        a_r3_group_blocked: assert property (@(posedge clk) disable iff (!por_n)
            !slot_en[g] |-> (ivec_out[g*PER_GRP +: PER_GRP] == '0));
    end

    for (genvar b = 0; b < N_BRD; b++) begin : g_brd
        assign ivec_out[N_SLOT_LINES + b] = irq_in[N_SLOT_LINES + b] & brd_en[b];
    end

    // R5: an output is never high while its input is low
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!por_n)
        ((ivec_out & ~irq_in) == '0));

endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int N_SLOT_REG = 8,
    parameter int LINES_PER  = 4,
    parameter int N_BRD_REG  = 16,
    parameter int SLOT_BASE  = 'hC00,
    parameter int BRD_BASE   = 'h1000,
    localparam int N_LINES   = N_SLOT_REG * LINES_PER + N_BRD_REG
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               dev_rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] ivec_out
);
    localparam int SIW = (N_SLOT_REG > 1) ? $clog2(N_SLOT_REG) : 1;
    localparam int BIW = (N_BRD_REG > 1) ? $clog2(N_BRD_REG) : 1;

    irq_region_e           region;
    logic [SIW-1:0]        slot_idx;
    logic [BIW-1:0]        brd_idx;
    logic [N_SLOT_REG-1:0] slot_en;
    logic [N_BRD_REG-1:0]  brd_en;
    logic                  slot_wr;
    logic                  brd_wr;
    logic                  unused_wdata;

    assign unused_wdata = ^reg_wdata[30:0];

    irq_route_decode #(
        .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .N_SLOT(N_SLOT_REG),
        .BRD_BASE(BRD_BASE), .N_BRD(N_BRD_REG), .SIW(SIW), .BIW(BIW)
    ) u_decode (
        .addr(reg_addr), .region(region), .slot_idx(slot_idx), .brd_idx(brd_idx)
    );

    assign slot_wr = reg_wr && (region == RG_SLOT);
    assign brd_wr  = reg_wr && (region == RG_BOARD);

    irq_route_enbank #(.N(N_SLOT_REG), .IW(SIW)) u_slot_bank (
        .clk(clk), .por_n(por_n), .clr(dev_rst), .wr(slot_wr),
        .idx(slot_idx), .wen(reg_wdata[31]), .en(slot_en)
    );

    irq_route_enbank #(.N(N_BRD_REG), .IW(BIW)) u_brd_bank (
        .clk(clk), .por_n(por_n), .clr(1'b0), .wr(brd_wr),
        .idx(brd_idx), .wen(reg_wdata[31]), .en(brd_en)
    );

    irq_route_gate #(.N_GRP(N_SLOT_REG), .PER_GRP(LINES_PER), .N_BRD(N_BRD_REG)) u_gate (
        .clk(clk), .por_n(por_n), .irq_in(irq_in),
        .slot_en(slot_en), .brd_en(brd_en), .ivec_out(ivec_out)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RG_SLOT:  reg_rdata = {slot_en[slot_idx], slot_low_bits(32'(slot_idx))};
            RG_BOARD: reg_rdata = {brd_en[brd_idx], 31'd0};
            default:  reg_rdata = '0;
        endcase
    end

    // R6: the lower word of every slot reads as zero
    a_r6_lower_zero: assert property (@(posedge clk) disable iff (!por_n)
        !reg_addr[2] |-> (reg_rdata == 32'd0));

    // R9: a slot write in a reset cycle leaves its enable cleared
    a_r9_reset_beats_write: assert property (@(posedge clk) disable iff (!por_n)
        (dev_rst && slot_wr) |=> (slot_en == '0));

endmodule

// File: tb/irq_route_unit_tb.sv
module irq_route_unit_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        dev_rst = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [47:0] irq_in = '0;
    logic [47:0] ivec_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic slot_m [8];
    logic brd_m  [16];

    always #5 clk = ~clk;

    irq_route_unit u_dut (
        .clk(clk), .por_n(por_n), .dev_rst(dev_rst), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .ivec_out(ivec_out)
    );

    // {addr[15:0], wdata[31:0], expected readback[31:0]}
    localparam logic [79:0] TBL [12] = '{
        {16'h0C04, 32'h8000_0000, 32'h8000_07C0},
        {16'h0C0C, 32'hFFFF_FFFF, 32'h8000_07C4},
        {16'h0C3C, 32'h8000_0000, 32'h8000_07DC},
        {16'h0C0C, 32'h7FFF_FFFF, 32'h0000_07C4},
        {16'h1004, 32'h8000_0000, 32'h8000_0000},
        {16'h107C, 32'h8000_0000, 32'h8000_0000},
        {16'h0C00, 32'hFFFF_FFFF, 32'h0000_0000},
        {16'h1008, 32'hFFFF_FFFF, 32'h0000_0000},
        {16'h0C4C, 32'h8000_0000, 32'h0000_0000},
        {16'h108C, 32'h8000_0000, 32'h0000_0000},
        {16'h0C14, 32'h8000_0000, 32'h8000_07C8},
        {16'h0BFC, 32'h8000_0000, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Requirement-level model of a write (R2, R6, R7, R8, R9)
    task automatic model_write(input logic [15:0] a, input logic [31:0] d, input logic rst);
        int ia;
        ia = int'(a);
        if (rst) begin
            for (int i = 0; i < 8; i++) slot_m[i] = 1'b0;
        end
        if (a[2]) begin
            if (ia >= 'hC00 && ia < 'hC40 && !rst) slot_m[(ia - 'hC00) / 8] = d[31];
            if (ia >= 'h1000 && ia < 'h1080) brd_m[(ia - 'h1000) / 8] = d[31];
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic rst);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; dev_rst = rst;
        @(negedge clk);
        reg_wr = 1'b0; dev_rst = 1'b0;
        model_write(a, d, rst);
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        #1 d = reg_rdata;
    endtask

    function automatic logic [47:0] exp_out(input logic [47:0] x);
        logic [47:0] r;
        for (int j = 0; j < 48; j++) begin
            r[j] = x[j] & ((j < 32) ? slot_m[j >> 2] : brd_m[j - 32]);
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [47:0] pats [5];
        for (int i = 0; i < 8; i++) slot_m[i] = 1'b0;
        for (int i = 0; i < 16; i++) brd_m[i] = 1'b0;
        pats = '{48'hFFFF_FFFF_FFFF, 48'hAAAA_AAAA_AAAA, 48'h5555_5555_5555,
                 48'h8000_0000_0001, 48'h0000_F000_000F};

        // R1: outputs held low during and after power-on reset
        irq_in = '1;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", 64'(ivec_out), 64'd0);
        por_n = 1'b1;
        @(negedge clk);
        #1 chk("R1 outputs after reset", 64'(ivec_out), 64'd0);
        for (int i = 0; i < 8; i++) begin
            rd(16'(16'h0C04 + 8 * i), d);
            chk("R1 slot init value", 64'(d), 64'(32'h7C0 | (i << 2)));
        end
        for (int k = 0; k < 16; k++) begin
            rd(16'(16'h1004 + 8 * k), d);
            chk("R1 board init value", 64'(d), 64'd0);
        end

        // R10: readback changes only after the clock edge of the write
        @(negedge clk);
        reg_addr = 16'h0C04; reg_wdata = 32'h8000_0000; reg_wr = 1'b1;
        #1 chk("R10 before edge", 64'(reg_rdata), 64'h7C0);
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(16'h0C04, 32'h8000_0000, 1'b0);
        #1 chk("R10 after edge", 64'(reg_rdata), 64'h8000_07C0);

        // R2/R6/R7: write-then-read table
        for (int t = 0; t < 12; t++) begin
            wr(TBL[t][79:64], TBL[t][63:32], 1'b0);
            rd(TBL[t][79:64], d);
            chk("R2/R6/R7 table readback", 64'(d), 64'(TBL[t][31:0]));
        end
        // R6: lower-word writes left their neighbours alone
        rd(16'h0C04, d); chk("R6 slot0 untouched", 64'(d), 64'h8000_07C0);
        rd(16'h100C, d); chk("R6 board1 untouched", 64'(d), 64'd0);
        // R7: out-of-window writes did not alias
        rd(16'h0C0C, d); chk("R7 slot1 untouched", 64'(d), 64'h7C4);
        rd(16'h1000, d); chk("R7 board0 lower zero", 64'(d), 64'd0);

        // R3/R4/R5: gating under several input patterns
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); irq_in = pats[p];
            #1 chk("R3/R4/R5 pattern", 64'(ivec_out), 64'(exp_out(pats[p])));
        end
        for (int j = 0; j < 48; j++) begin
            @(negedge clk); irq_in = 48'd1 << j;
            #1 chk((j < 32) ? "R3 walking one" : "R4 walking one",
                   64'(ivec_out), 64'(exp_out(48'd1 << j)));
        end

        // R5: disable write and live input in the same cycle
        @(negedge clk);
        irq_in = '1;
        reg_addr = 16'h0C04; reg_wdata = 32'h0; reg_wr = 1'b1;
        #1 chk("R5 live before edge", 64'(ivec_out[3:0]), 64'hF);
        @(posedge clk);
        #1 chk("R5 dropped after edge", 64'(ivec_out[3:0]), 64'h0);
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(16'h0C04, 32'h0, 1'b0);
        wr(16'h0C04, 32'h8000_0000, 1'b0);
        #1 chk("R5 follows again", 64'(ivec_out), 64'(exp_out('1)));

        // R8: device reset clears slot enables only
        @(negedge clk); dev_rst = 1'b1;
        @(negedge clk); dev_rst = 1'b0;
        model_write(16'h0000, 32'h0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            rd(16'(16'h0C04 + 8 * i), d);
            chk("R8 slot cleared, low bits kept", 64'(d), 64'(32'h7C0 | (i << 2)));
        end
        rd(16'h1004, d); chk("R8 board0 kept", 64'(d), 64'h8000_0000);
        rd(16'h107C, d); chk("R8 board15 kept", 64'(d), 64'h8000_0000);
        #1 chk("R8 outputs", 64'(ivec_out), 64'h8001_0000_0000);

        // R9: device reset coinciding with writes
        wr(16'h0C14, 32'h8000_0000, 1'b1);
        rd(16'h0C14, d); chk("R9 slot write loses", 64'(d), 64'h7C8);
        wr(16'h100C, 32'h8000_0000, 1'b1);
        rd(16'h100C, d); chk("R9 board write wins", 64'(d), 64'h8000_0000);
        #1 chk("R9 outputs", 64'(ivec_out), 64'(exp_out('1)));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule